// File: doc/BRIEF.md
# I2C Target Transmit Engine with NACK Flush

This block is the transmit side of an I2C target that uses 7-bit addressing. Both bus lines are sampled by an oversampling serial clock. The block finds START and STOP conditions and compares each incoming address byte against its own address. When a read addressed to it arrives, it returns bytes from a transmit FIFO. Software on a separate bus clock fills the FIFO and watches a status word. A read-request bit asks software for data, and a transmit-abort pulse reports that unsent bytes were thrown away.

The serial engine and the FIFO sit in different clock domains. The engine never touches the FIFO directly. It sends one operation at a time over a toggle handshake: raise a read request, fetch the first byte, fetch the next byte after an ACK, or flush after a NACK. The bus side performs the operation and toggles an acknowledge back. As long as the remote controller acknowledges and the FIFO holds data, bytes follow each other with no new request. When the controller ends the read with a NACK, the leftover bytes are cleared on the bus side.

Top module: `i2c_tgt_tx`

## Requirements
- R1: After reset the status word is zero, the FIFO count is zero, SDA is released (`sda_oe_o` low) and `tx_abrt_o` is low.
- R2: A `wr_en_i` pulse appends `wr_data_i` to the FIFO when it holds fewer than DEPTH bytes. A write while full is dropped. `fifo_count_o` gives the number of bytes held.
- R3: After a START, the block receives 8 bits MSB first: a 7-bit address followed by a direction bit, where 1 means read. Only a matching address with the direction bit at 1 makes the block pull SDA low for the ninth clock (ACK). Any other address byte leaves SDA released.
- R4: A matching read address sets status bit 5 (read request).
- R5: Status bits 5 and 6 stay set until cleared by a one-cycle pulse on `clr_rd_i` or `clr_ab_i`, respectively. A new set event wins over a clear in the same cycle.
- R6: Data bytes are sent MSB first, each bit changing after an SCL fall. The first byte is taken from the FIFO after the address ACK. While the controller ACKs and the FIFO is not empty, further bytes follow without setting status bit 5.
- R7: If the controller ACKs a byte and the FIFO is then empty, status bit 5 is set and the next byte sent is 0xFF (SDA left released).
- R8: A NACK in the acknowledge slot ends the transfer and empties the FIFO.
- R9: A NACK flush that discards at least one byte gives exactly one single-cycle `tx_abrt_o` pulse and sets status bit 6. A NACK with an already empty FIFO gives neither.
- R10: A START or STOP in the middle of a byte returns the engine to idle without any flush. The FIFO keeps its remaining bytes, and a following read is served normally.
- R11: SDA is released during the acknowledge slot after every data byte.
- R12: The engine issues at most one operation at a time across the clock boundary, so each flush is performed exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bus clock (FIFO, status) |
| sclk_i | input | 1 | Oversampling serial clock |
| rst_i | input | 1 | Synchronous active-high reset, held across both clocks |
| own_addr_i | input | ADDR_W | Own 7-bit target address |
| wr_en_i | input | 1 | FIFO write strobe (bus clock) |
| wr_data_i | input | DW | FIFO write data |
| clr_rd_i | input | 1 | Clear pulse for status bit 5 |
| clr_ab_i | input | 1 | Clear pulse for status bit 6 |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| status_o | output | 8 | Status word: bit 5 read request, bit 6 abort |
| tx_abrt_o | output | 1 | One-cycle transmit-abort pulse |
| fifo_count_o | output | $clog2(DEPTH+1) | Bytes held in the FIFO |

## Verification
The bench builds the block with DEPTH = 4. At that depth a handful of writes reaches the full condition, so the dropped write and a flush that discards several bytes both occur in short transactions. The SCL half period is about fifty serial clocks. This leaves every handshake round trip well inside one SCL phase, so the bench can check byte values, ACK slots and the empty-FIFO 0xFF case at the bit level. It can also check the mid-byte STOP without relying on clock stretching.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [1:0] {
    OP_RDREQ = 2'd0,
    OP_LOAD  = 2'd1,
    OP_NEXT  = 2'd2,
    OP_FLUSH = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AWAIT, S_AACK, S_TX, S_TACK, S_TEND
  } st_e;

  localparam int STAT_RD_BIT = 5;
  localparam int STAT_AB_BIT = 6;
endpackage

// File: rtl/tgt_sync.sv
module tgt_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tgt_fifo.sv
module tgt_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [DW-1:0]              wdata,
  input  logic                       rd,
  input  logic                       flush,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, do_wr, do_rd;

  assign full  = (count == FULL);
  assign empty = (count == '0);
  assign do_wr = wr && !full && !flush;
  assign do_rd = rd && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
    if (do_rd) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      rptr  <= wptr;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == PMAX) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == PMAX) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && full && !rd && !flush) |=> (count == $past(count)))
    else $error("write accepted while full");

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0))
    else $error("flush left bytes behind");
endmodule

// File: rtl/tgt_bus_side.sv
module tgt_bus_side import i2c_tgt_pkg::*; #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       op_req_i,
  input  op_e                        op_code_i,
  output logic                       op_ack_o,
  output logic [DW-1:0]              ret_byte_o,
  input  logic                       wr_en_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic                       clr_rd_i,
  input  logic                       clr_ab_i,
  output logic [7:0]                 status_o,
  output logic                       tx_abrt_o,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count_o
);
  logic          req_s, req_d, new_op, pend;
  logic          fifo_rd, fifo_fl, empty, fill_q;
  logic          set_rd, set_ab, st_rd, st_ab;
  logic [DW-1:0] fifo_q;

  tgt_sync #(.W(1), .INIT(1'b0)) u_req_sync (
    .clk(clk), .rst(rst), .d(op_req_i), .q(req_s));

  assign new_op  = req_s ^ req_d;
  assign fifo_rd = new_op && (op_code_i == OP_LOAD || op_code_i == OP_NEXT) && !empty;
  assign fifo_fl = new_op && (op_code_i == OP_FLUSH);
  assign set_rd  = new_op && (op_code_i == OP_RDREQ || (op_code_i == OP_NEXT && empty));
  assign set_ab  = fifo_fl && !empty;

  tgt_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr(wr_en_i), .wdata(wr_data_i),
    .rd(fifo_rd), .flush(fifo_fl), .rdata(fifo_q),
    .count(fifo_count_o), .empty(empty));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d     <= 1'b0;
      pend      <= 1'b0;
      op_ack_o  <= 1'b0;
      fill_q    <= 1'b0;
      st_rd     <= 1'b0;
      st_ab     <= 1'b0;
      tx_abrt_o <= 1'b0;
    end else begin
      req_d     <= req_s;
      pend      <= new_op;
      if (pend) op_ack_o <= ~op_ack_o;
      if (new_op) fill_q <= fifo_rd;
      st_rd     <= set_rd | (st_rd & ~clr_rd_i);
      st_ab     <= set_ab | (st_ab & ~clr_ab_i);
      tx_abrt_o <= set_ab;
    end
  end

  assign ret_byte_o = fill_q ? fifo_q : {DW{1'b1}};

  always_comb begin
    status_o = '0;
    status_o[STAT_RD_BIT] = st_rd;
    status_o[STAT_AB_BIT] = st_ab;
  end

  p_abort_single_r9: assert property (@(posedge clk) disable iff (rst)
    tx_abrt_o |=> !tx_abrt_o)
    else $error("abort pulse longer than one cycle");

  p_abort_status_r9: assert property (@(posedge clk) disable iff (rst)
    tx_abrt_o |-> status_o[STAT_AB_BIT])
    else $error("abort pulse without status bit");

  p_rd_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (status_o[STAT_RD_BIT] && !clr_rd_i) |=> status_o[STAT_RD_BIT])
    else $error("read request dropped without clear");
endmodule

// File: rtl/tgt_serial.sv
module tgt_serial import i2c_tgt_pkg::*; #(
  parameter int DW     = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              op_ack_i,
  input  logic [DW-1:0]     ret_byte_i,
  output logic              op_req_o,
  output op_e               op_code_o,
  output logic              sda_oe_o
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  logic [1:0]        pins_s;
  logic              scl_s, sda_s, scl_d, sda_d, ack_s, ack_d;
  logic              scl_rise, scl_fall, start_c, stop_c, hit, busy;
  logic              issue;
  op_e               issue_code;
  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] rx;
  logic [DW-1:0]     tx;

  tgt_sync #(.W(2), .INIT(2'b11)) u_pin_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(pins_s));
  tgt_sync #(.W(1), .INIT(1'b0)) u_ack_sync (
    .clk(clk), .rst(rst), .d(op_ack_i), .q(ack_s));

  assign scl_s    = pins_s[1];
  assign sda_s    = pins_s[0];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign hit      = (rx == own_addr_i) && sda_s;
  assign busy     = op_req_o ^ ack_s;

  always_comb begin
    issue      = 1'b0;
    issue_code = OP_RDREQ;
    if (!start_c && !stop_c) begin
      case (st)
        S_ADDR: if (scl_rise && cnt == LAST && hit) issue = 1'b1;
        S_AACK: if (scl_fall) begin issue = 1'b1; issue_code = OP_LOAD; end
        S_TACK: if (scl_rise) begin
          issue      = 1'b1;
          issue_code = sda_s ? OP_FLUSH : OP_NEXT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '1;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      ack_d     <= 1'b0;
      op_req_o  <= 1'b0;
      op_code_o <= OP_RDREQ;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      ack_d <= ack_s;
      if (issue) begin
        op_req_o  <= ~op_req_o;
        op_code_o <= issue_code;
      end
      if (start_c) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else if (stop_c) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_ADDR: if (scl_rise) begin
            rx <= {rx[ADDR_W-2:0], sda_s};
            if (cnt == LAST) st <= hit ? S_AWAIT : S_IDLE;
            else             cnt <= cnt + 1'b1;
          end
          S_AWAIT: if (scl_fall) st <= S_AACK;
          S_AACK:  if (scl_fall) begin st <= S_TX; cnt <= '0; end
          S_TX:    if (scl_fall) begin
            tx <= {tx[DW-2:0], 1'b1};
            if (cnt == LAST) st <= S_TACK;
            else             cnt <= cnt + 1'b1;
          end
          S_TACK:  if (scl_rise) st <= sda_s ? S_IDLE : S_TEND;
          S_TEND:  if (scl_fall) begin st <= S_TX; cnt <= '0; end
          default: st <= S_IDLE;
        endcase
      end
      if ((ack_s ^ ack_d) && (op_code_o == OP_LOAD || op_code_o == OP_NEXT))
        tx <= ret_byte_i;
    end
  end

  assign sda_oe_o = (st == S_AACK) || (st == S_TX && !tx[DW-1]);

  p_one_op_r12: assert property (@(posedge clk) disable iff (rst)
    issue |-> !busy)
    else $error("new operation while previous one pending");

  p_ack_release_r11: assert property (@(posedge clk) disable iff (rst)
    (st == S_TX && scl_fall && cnt == LAST && !start_c && !stop_c) |=> !sda_oe_o)
    else $error("SDA held in acknowledge slot");

  p_start_addr_r10: assert property (@(posedge clk) disable iff (rst)
    start_c |=> (st == S_ADDR))
    else $error("START did not restart address phase");
endmodule

// File: rtl/i2c_tgt_tx.sv
module i2c_tgt_tx import i2c_tgt_pkg::*; #(
  parameter int DW     = 8,
  parameter int ADDR_W = 7,
  parameter int DEPTH  = 8
) (
  input  logic                       bclk_i,
  input  logic                       sclk_i,
  input  logic                       rst_i,
  input  logic [ADDR_W-1:0]          own_addr_i,
  input  logic                       wr_en_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic                       clr_rd_i,
  input  logic                       clr_ab_i,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [7:0]                 status_o,
  output logic                       tx_abrt_o,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count_o
);
  logic          op_req, op_ack;
  op_e           op_code;
  logic [DW-1:0] ret_byte;

  tgt_serial #(.DW(DW), .ADDR_W(ADDR_W)) u_serial (
    .clk(sclk_i), .rst(rst_i), .scl_i(scl_i), .sda_i(sda_i),
    .own_addr_i(own_addr_i), .op_ack_i(op_ack), .ret_byte_i(ret_byte),
    .op_req_o(op_req), .op_code_o(op_code), .sda_oe_o(sda_oe_o));

  tgt_bus_side #(.DW(DW), .DEPTH(DEPTH)) u_bus (
    .clk(bclk_i), .rst(rst_i), .op_req_i(op_req), .op_code_i(op_code),
    .op_ack_o(op_ack), .ret_byte_o(ret_byte), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .clr_rd_i(clr_rd_i), .clr_ab_i(clr_ab_i),
    .status_o(status_o), .tx_abrt_o(tx_abrt_o), .fifo_count_o(fifo_count_o));
endmodule

// File: tb/sim_i2c_tgt_tx.sv
`timescale 1ns/1ps
module sim_i2c_tgt_tx;
  localparam int DEPTH = 4;
  localparam int H = 250;
  localparam logic [6:0] OWN = 7'h5A;

  logic bclk = 0, sclk = 0, rst = 1;
  logic wr_en = 0, clr_rd = 0, clr_ab = 0;
  logic [7:0] wr_data = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, abrt;
  logic [7:0] status;
  logic [2:0] fcount;
  logic sda_bus;

  int n_cmp = 0, n_bad = 0, n_ab = 0, exp_ab_n = 0;
  bit quiet = 0, done = 0, exp_rd = 0, exp_ab = 0;
  logic [7:0] q[$];

  assign sda_bus = sda_m & ~sda_oe;

  always #2 bclk = ~bclk;
  always #2.5 sclk = ~sclk;

  i2c_tgt_tx #(.DEPTH(DEPTH)) u0 (
    .bclk_i(bclk), .sclk_i(sclk), .rst_i(rst), .own_addr_i(OWN),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .clr_rd_i(clr_rd), .clr_ab_i(clr_ab),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe), .status_o(status),
    .tx_abrt_o(abrt), .fifo_count_o(fcount));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge bclk) if (!rst && abrt) n_ab++;

  // reference model compared on every bus clock while no transfer is in flight
  always @(negedge bclk) if (quiet && !rst) begin
    chk(fcount == q.size(), "R2", "count per clock", fcount, q.size());
    chk(status[5] == exp_rd && status[6] == exp_ab, "R5", "status per clock",
        status, {1'b0, exp_ab, exp_rd, 5'b0});
  end

  task automatic wr_byte(input logic [7:0] b);
    quiet = 0;
    @(negedge bclk); wr_en = 1; wr_data = b;
    @(negedge bclk); wr_en = 0;
    if (q.size() < DEPTH) q.push_back(b);
    @(negedge bclk); quiet = 1;
  endtask

  task automatic pulse_clr(input bit rd, input bit ab);
    @(negedge bclk); clr_rd = rd; clr_ab = ab;
    @(negedge bclk); clr_rd = 0; clr_ab = 0;
    if (rd) exp_rd = 0;
    if (ab) exp_ab = 0;
  endtask

  task automatic i2c_start();
    sda_m = 1; scl_m = 1; #H; sda_m = 0; #H; scl_m = 0;
  endtask

  task automatic i2c_stop();
    #(H/2) sda_m = 0; #(H/2) scl_m = 1; #H sda_m = 1; #H;
  endtask

  task automatic addr_phase(input logic [6:0] a, input bit rw, output bit sack);
    logic [7:0] b;
    b = {a, rw};
    i2c_start();
    for (int i = 7; i >= 0; i--) begin
      #(H/2) sda_m = b[i]; #(H/2) scl_m = 1; #H scl_m = 0;
    end
    #(H/2) sda_m = 1; #(H/2) scl_m = 1; #(H/2) sack = sda_bus; #(H/2) scl_m = 0;
  endtask

  task automatic rd_byte(input bit mnack, output logic [7:0] got);
    got = 0;
    for (int i = 7; i >= 0; i--) begin
      #H scl_m = 1; #(H/2) got[i] = sda_bus; #(H/2) scl_m = 0;
    end
    #(H/2) sda_m = mnack; #(H/2) scl_m = 1; #(H/2);
    chk(sda_oe == 0, "R11", "SDA released in ack slot", sda_oe, 0);
    #(H/2) scl_m = 0; #(H/4) sda_m = 1;
  endtask

  function automatic logic [7:0] fetch(input bit after_ack);
    if (q.size() > 0) return q.pop_front();
    if (after_ack) exp_rd = 1;
    return 8'hFF;
  endfunction

  function automatic void nack_flush();
    if (q.size() > 0) begin exp_ab = 1; exp_ab_n++; end
    q.delete();
  endfunction

  // full read transaction of n bytes, last one NACKed
  task automatic read_xfer(input int n, input string req, input bit clr_first);
    bit sack;
    logic [7:0] got, exp;
    quiet = 0;
    addr_phase(OWN, 1'b1, sack);
    chk(sack == 0, "R3", "ACK on own read address", sack, 0);
    exp_rd = 1;
    chk(status[5] == 1, "R4", "read request after address", status[5], 1);
    if (clr_first) pulse_clr(1, 0);
    for (int k = 0; k < n; k++) begin
      exp = fetch(k != 0);
      rd_byte(k == n - 1, got);
      chk(got == exp, req, "byte returned", got, exp);
    end
    nack_flush();
    i2c_stop();
    repeat (40) @(negedge bclk);
    chk(fcount == q.size(), "R8", "count after NACK", fcount, q.size());
    chk(n_ab == exp_ab_n, "R9", "abort pulses", n_ab, exp_ab_n);
    chk(status[5] == exp_rd, req, "read request after transfer", status[5], exp_rd);
    quiet = 1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL ALL: watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    bit sack;
    logic [7:0] got;
    repeat (20) @(negedge bclk);
    rst = 0;
    repeat (10) @(negedge bclk);
    // R1 reset state
    chk(status == 0, "R1", "status after reset", status, 0);
    chk(fcount == 0, "R1", "count after reset", fcount, 0);
    chk(sda_oe == 0 && abrt == 0, "R1", "SDA and abort idle", {sda_oe, abrt}, 0);
    quiet = 1;

    // R2 fill
    wr_byte(8'hA1); wr_byte(8'hB2); wr_byte(8'hC3);
    chk(fcount == 3, "R2", "count after three writes", fcount, 3);

    // R3 foreign address and write direction are ignored
    quiet = 0;
    addr_phase(7'h33, 1'b1, sack);
    chk(sack == 1, "R3", "no ACK on foreign address", sack, 1);
    i2c_stop();
    addr_phase(OWN, 1'b0, sack);
    chk(sack == 1, "R3", "no ACK on write direction", sack, 1);
    i2c_stop();
    repeat (20) @(negedge bclk);
    chk(status == 0, "R3", "no status from ignored addresses", status, 0);
    quiet = 1;

    // R6 stream of three; FIFO empties exactly at the NACK so no abort (R9)
    read_xfer(3, "R6", 1);
    chk(status[6] == 0, "R9", "no abort when nothing discarded", status[6], 0);

    // R2 full drop, then R8/R9 flush of leftover bytes
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44);
    wr_byte(8'h55);
    chk(fcount == DEPTH, "R2", "write while full dropped", fcount, DEPTH);
    read_xfer(2, "R6", 1);
    chk(status[6] == 1, "R9", "abort status set", status[6], 1);
    pulse_clr(0, 1);
    repeat (3) @(negedge bclk);
    chk(status[6] == 0, "R5", "abort bit cleared", status[6], 0);

    // R7 ACK with empty FIFO re-raises request and sends 0xFF
    wr_byte(8'h66);
    read_xfer(3, "R7", 1);
    pulse_clr(1, 0);

    // R10 STOP in the middle of a byte
    wr_byte(8'hFF); wr_byte(8'h77);
    quiet = 0;
    addr_phase(OWN, 1'b1, sack);
    exp_rd = 1;
    void'(fetch(0));
    for (int i = 0; i < 3; i++) begin
      #H scl_m = 1; #(H/2) got[i] = sda_bus; #(H/2) scl_m = 0;
    end
    #(H/2) sda_m = 0; #(H/2) scl_m = 1; #H sda_m = 1; #H;
    repeat (40) @(negedge bclk);
    chk(fcount == 1, "R10", "no flush on mid-byte STOP", fcount, 1);
    chk(n_ab == exp_ab_n, "R10", "no abort on mid-byte STOP", n_ab, exp_ab_n);
    pulse_clr(1, 0);
    quiet = 1;
    read_xfer(1, "R10", 1);
    chk(n_ab == exp_ab_n, "R12", "flush counted once", n_ab, exp_ab_n);

    repeat (10) @(negedge bclk);
    done = 1;
    finish_run();
  end
endmodule